// File: doc/BRIEF.md
# Virtual Function Configuration Register File

This block holds the configuration-space dwords for a parameterised set of virtual functions (VFs) that sit under one parent physical function. A request selects a VF by index and a dword within that VF's 4 KB space. Reads return one of four kinds of value: a constant, a copy of a parent-function setting, the VF's own stored bits, or zero. Writes update the VF's bus-master enable, clear latched status bits, or request a Function-Level Reset (FLR).

The transaction layer reports error and completion events on a side port, tagged with a VF index. The block latches these events into the VF's status bits. Two of those bits are set only while the parent function's matching enable is on. An accepted FLR request produces a single-cycle pulse for that VF, and the pulse returns the VF's stored state to its reset values.

Requests are accepted on every cycle in which `req_valid` is high. Reads answer exactly one cycle later. Writes produce no response.

Top module: `vf_cfg_regfile`

## Requirements
- R1: Every read accepted on a clock edge drives `rsp_valid` high with its data for exactly the following cycle. A write never drives `rsp_valid`.
- R2: Byte offset 0x000 reads 0xFFFFFFFF. Offset 0x00C reads 0. Offset 0x034 reads 0x0000007C, the offset of the MSI-X capability. Offset 0x040 reads 0x00020010, which is capability ID 0x10, next pointer 0, version 2 in bits 18:16.
- R3: Offset 0x04C returns `pf_link_cap` and offset 0x054 returns `pf_devcap2`. Offset 0x060 returns `pf_deemph` in bit 16 and 0 in every other bit.
- R4: Offsets 0x050, 0x058 and 0x05C read 0, and so does every other offset not listed in R2, R3, R5 or R10. Writes to any of these offsets change no state.
- R5: At offset 0x004, bit 2 is a per-VF read-write bus-master enable that resets to 0, and bit 20 always reads 1. All other bits of the lower half read 0. After reset the dword reads 0x00100000.
- R6: Offset 0x004 bit 24 is set by an event with `ev_bits[0]` (poisoned completion received) or `ev_bits[1]` (poisoned write sent), but only while `pf_perr_en` is 1.
- R7: Offset 0x004 bits 27, 28 and 29 are set by `ev_bits[2]` (completer abort sent), `ev_bits[3]` (completer abort received) and `ev_bits[4]` (unsupported request received) respectively.
- R8: Offset 0x004 bit 30 is set by `ev_bits[5]` (error message sent), but only while `pf_serr_en` is 1.
- R9: Writing 1 clears status bits 24 and 27 to 30 at offset 0x004, and bits 16 to 19 at offset 0x048. Writing 0 to any of these bits leaves it unchanged.
- R10: Offset 0x048 bits 16, 17, 18 and 19 are set by `ev_bits[6]` (correctable), `ev_bits[7]` (non-fatal), `ev_bits[8]` (fatal) and `ev_bits[9]` (unsupported request detected). Bit 21 shows `tx_pending[vf]` as sampled when the read is accepted. Bits 15:0 and all other bits read 0.
- R11: A write to offset 0x048 with bit 15 set, while `pf_flr_cap` is 1, drives `flr_pulse[vf]` high for exactly the following cycle. The same write with `pf_flr_cap` at 0 gives no pulse. At most one pulse bit is high at a time.
- R12: On the edge that ends an FLR pulse, the pulsed VF's bus-master enable and all of its status bits return to 0. Every other VF is unaffected.
- R13: If an event sets a status bit on the same edge that a write of 1 clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vf | input | VF_IDX_W | Target VF index |
| req_dword | input | 10 | Dword index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ev_valid | input | 1 | Event bits apply on this edge |
| ev_vf | input | VF_IDX_W | VF the events belong to |
| ev_bits | input | 10 | Event flags, positions as in R6–R10 |
| tx_pending | input | NUM_VF | Per-VF non-posted request outstanding |
| pf_perr_en | input | 1 | Parent parity-error-response enable |
| pf_serr_en | input | 1 | Parent system-error enable |
| pf_flr_cap | input | 1 | Parent advertises FLR capability |
| pf_link_cap | input | 32 | Parent link capabilities value |
| pf_devcap2 | input | 32 | Parent device capabilities 2 value |
| pf_deemph | input | 1 | Parent current de-emphasis level |
| flr_pulse | output | NUM_VF | One-cycle per-VF FLR pulse |

## Verification
A read presented in one cycle is answered in the next cycle. A write or event presented in one cycle affects a read presented in any later cycle. An FLR pulse appears in the cycle after its write, and the VF's state is cleared at the edge that ends that cycle. The bench drives every request at a falling edge and holds it for one cycle. It pushes the expected read data into a queue at the moment it drives the read. A monitor pops the queue at each falling edge where `rsp_valid` is high, so each response is compared exactly one cycle after its request. FLR pulses are sampled at the first and second falling edges after the write.

// File: rtl/vf_cfg_pkg.sv
// Package: shared constants and types for the VF configuration register file.
// Assumes dword-indexed addressing (byte offset / 4) within a 4 KB space.
package vf_cfg_pkg;

    localparam int DW_W = 10;
    localparam int EV_W = 10;

    // Dword indices of the decoded locations
    localparam logic [DW_W-1:0] DW_IDENT  = 10'h000;
    localparam logic [DW_W-1:0] DW_CMDSTS = 10'h001;
    localparam logic [DW_W-1:0] DW_HDRMSC = 10'h003;
    localparam logic [DW_W-1:0] DW_CAPPTR = 10'h00D;
    localparam logic [DW_W-1:0] DW_PCIECL = 10'h010;
    localparam logic [DW_W-1:0] DW_DEVCS  = 10'h012;
    localparam logic [DW_W-1:0] DW_LNKCAP = 10'h013;
    localparam logic [DW_W-1:0] DW_DCAP2  = 10'h015;
    localparam logic [DW_W-1:0] DW_LNKCS2 = 10'h018;

    // Event flag positions
    localparam int EV_POIS_RX  = 0;
    localparam int EV_POIS_TX  = 1;
    localparam int EV_CA_SENT  = 2;
    localparam int EV_CA_RCVD  = 3;
    localparam int EV_UR_RCVD  = 4;
    localparam int EV_ERRMSG   = 5;
    localparam int EV_CORR     = 6;
    localparam int EV_NONFATAL = 7;
    localparam int EV_FATAL    = 8;
    localparam int EV_UR_DET   = 9;

    // Bit positions inside the command/status and device control/status dwords
    localparam int B_BME   = 2;
    localparam int B_EXTCP = 20;
    localparam int B_PERR  = 24;
    localparam int B_STA   = 27;
    localparam int B_RTA   = 28;
    localparam int B_RMA   = 29;
    localparam int B_SSE   = 30;
    localparam int B_FLR   = 15;
    localparam int B_CED   = 16;
    localparam int B_NFED  = 17;
    localparam int B_FED   = 18;
    localparam int B_URD   = 19;
    localparam int B_TPND  = 21;
    localparam int B_DEEMP = 16;

    localparam logic [7:0]  MSIX_CAP_OFS  = 8'h7C;
    localparam logic [31:0] PCIE_CAP_WORD = 32'h0002_0010;

    // Per-VF stored state
    typedef struct packed {
        logic sse;
        logic rma;
        logic rta;
        logic sta;
        logic perr;
        logic urd;
        logic fed;
        logic nfed;
        logic ced;
        logic bme;
    } vf_state_t;

endpackage

// File: rtl/vf_cfg_state.sv
// Module: stored state of one VF (bus-master enable and sticky status bits).
// Assumes the decode strobes are already qualified with this VF's index.
// Priority on an edge: FLR clear, then event set, then write-one-to-clear.
module vf_cfg_state
    import vf_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cmd,
    input  logic            wr_devcs,
    input  logic [31:0]     wdata,
    input  logic            ev_hit,
    input  logic [EV_W-1:0] ev_bits,
    input  logic            pf_perr_en,
    input  logic            pf_serr_en,
    input  logic            flr_clr,
    output vf_state_t       st
);

    vf_state_t nxt;

    // Next-state: writes, then gated event sets, then FLR clear
    always_comb begin
        nxt = st;
        if (wr_cmd) begin
            nxt.bme  = wdata[B_BME];
            nxt.perr = nxt.perr & ~wdata[B_PERR];
            nxt.sta  = nxt.sta  & ~wdata[B_STA];
            nxt.rta  = nxt.rta  & ~wdata[B_RTA];
            nxt.rma  = nxt.rma  & ~wdata[B_RMA];
            nxt.sse  = nxt.sse  & ~wdata[B_SSE];
        end
        if (wr_devcs) begin
            nxt.ced  = nxt.ced  & ~wdata[B_CED];
            nxt.nfed = nxt.nfed & ~wdata[B_NFED];
            nxt.fed  = nxt.fed  & ~wdata[B_FED];
            nxt.urd  = nxt.urd  & ~wdata[B_URD];
        end
        if (ev_hit) begin
            if ((ev_bits[EV_POIS_RX] || ev_bits[EV_POIS_TX]) && pf_perr_en)
                nxt.perr = 1'b1;
            if (ev_bits[EV_CA_SENT]) nxt.sta = 1'b1;
            if (ev_bits[EV_CA_RCVD]) nxt.rta = 1'b1;
            if (ev_bits[EV_UR_RCVD]) nxt.rma = 1'b1;
            if (ev_bits[EV_ERRMSG] && pf_serr_en) nxt.sse = 1'b1;
            if (ev_bits[EV_CORR])     nxt.ced  = 1'b1;
            if (ev_bits[EV_NONFATAL]) nxt.nfed = 1'b1;
            if (ev_bits[EV_FATAL])    nxt.fed  = 1'b1;
            if (ev_bits[EV_UR_DET])   nxt.urd  = 1'b1;
        end
        if (flr_clr)
            nxt = '0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= nxt;
    end

endmodule

// File: rtl/vf_cfg_flr_gen.sv
// Module: per-VF Function-Level Reset pulse generator.
// Assumes flr_req is a single decoded write of the FLR bit; pulses last one cycle.
module vf_cfg_flr_gen #(
    parameter int NUM_VF   = 4,
    parameter int VF_IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flr_req,
    input  logic [VF_IDX_W-1:0] flr_vf,
    input  logic                pf_flr_cap,
    output logic [NUM_VF-1:0]   flr_pulse
);

    for (genvar i = 0; i < NUM_VF; i++) begin : g_pulse
        // One-cycle pulse for the addressed VF when the parent allows FLR
        always_ff @(posedge clk) begin
            if (!rst_n) flr_pulse[i] <= 1'b0;
            else        flr_pulse[i] <= flr_req && pf_flr_cap && (flr_vf == VF_IDX_W'(i));
        end
    end

endmodule

// File: rtl/vf_cfg_rd_port.sv
// Module: read decode and one-cycle registered read response.
// Assumes st holds every VF's state; an index beyond NUM_VF reads zero.
module vf_cfg_rd_port
    import vf_cfg_pkg::*;
#(
    parameter int NUM_VF   = 4,
    parameter int VF_IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [VF_IDX_W-1:0]     rd_vf,
    input  logic [DW_W-1:0]         rd_dw,
    input  vf_state_t [NUM_VF-1:0]  st,
    input  logic [NUM_VF-1:0]       tx_pending,
    input  logic [31:0]             pf_link_cap,
    input  logic [31:0]             pf_devcap2,
    input  logic                    pf_deemph,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata
);

    vf_state_t   sel;
    logic        sel_pend;
    logic [31:0] rd_word;

    // Select the addressed VF's state and pending flag
    always_comb begin
        sel      = '0;
        sel_pend = 1'b0;
        for (int i = 0; i < NUM_VF; i++) begin
            if (rd_vf == VF_IDX_W'(i)) begin
                sel      = st[i];
                sel_pend = tx_pending[i];
            end
        end
    end

    // Address decode into the read word
    always_comb begin
        rd_word = '0;
        unique case (rd_dw)
            DW_IDENT:  rd_word = '1;
            DW_CMDSTS: begin
                rd_word[B_BME]   = sel.bme;
                rd_word[B_EXTCP] = 1'b1;
                rd_word[B_PERR]  = sel.perr;
                rd_word[B_STA]   = sel.sta;
                rd_word[B_RTA]   = sel.rta;
                rd_word[B_RMA]   = sel.rma;
                rd_word[B_SSE]   = sel.sse;
            end
            DW_HDRMSC: rd_word = '0;
            DW_CAPPTR: rd_word = {24'h0, MSIX_CAP_OFS};
            DW_PCIECL: rd_word = PCIE_CAP_WORD;
            DW_DEVCS: begin
                rd_word[B_CED]  = sel.ced;
                rd_word[B_NFED] = sel.nfed;
                rd_word[B_FED]  = sel.fed;
                rd_word[B_URD]  = sel.urd;
                rd_word[B_TPND] = sel_pend;
            end
            DW_LNKCAP: rd_word = pf_link_cap;
            DW_DCAP2:  rd_word = pf_devcap2;
            DW_LNKCS2: rd_word[B_DEEMP] = pf_deemph;
            default:   rd_word = '0;
        endcase
    end

    // Response register: data due one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_word : '0;
        end
    end

endmodule

// File: rtl/vf_cfg_regfile.sv
// Module: top of the VF configuration register file.
// Decodes requests and events per VF, instantiates per-VF state, the FLR
// pulse generator and the read port. Assumes one request per cycle, always accepted.
module vf_cfg_regfile
    import vf_cfg_pkg::*;
#(
    parameter int NUM_VF   = 4,
    parameter int VF_IDX_W = $clog2(NUM_VF)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [VF_IDX_W-1:0] req_vf,
    input  logic [9:0]          req_dword,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    input  logic                ev_valid,
    input  logic [VF_IDX_W-1:0] ev_vf,
    input  logic [9:0]          ev_bits,
    input  logic [NUM_VF-1:0]   tx_pending,
    input  logic                pf_perr_en,
    input  logic                pf_serr_en,
    input  logic                pf_flr_cap,
    input  logic [31:0]         pf_link_cap,
    input  logic [31:0]         pf_devcap2,
    input  logic                pf_deemph,
    output logic [NUM_VF-1:0]   flr_pulse
);

    logic                   wr_any;
    logic                   rd_any;
    logic                   wr_cmd_dw;
    logic                   wr_devcs_dw;
    vf_state_t [NUM_VF-1:0] vf_st;

    // Request qualification
    always_comb begin
        wr_any      = req_valid && req_write;
        rd_any      = req_valid && !req_write;
        wr_cmd_dw   = wr_any && (req_dword == DW_CMDSTS);
        wr_devcs_dw = wr_any && (req_dword == DW_DEVCS);
    end

    for (genvar i = 0; i < NUM_VF; i++) begin : g_vf
        logic hit_req;
        logic hit_ev;
        assign hit_req = (req_vf == VF_IDX_W'(i));
        assign hit_ev  = ev_valid && (ev_vf == VF_IDX_W'(i));

        vf_cfg_state u_state (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_cmd     (wr_cmd_dw && hit_req),
            .wr_devcs   (wr_devcs_dw && hit_req),
            .wdata      (req_wdata),
            .ev_hit     (hit_ev),
            .ev_bits    (ev_bits),
            .pf_perr_en (pf_perr_en),
            .pf_serr_en (pf_serr_en),
            .flr_clr    (flr_pulse[i]),
            .st         (vf_st[i])
        );
    end

    vf_cfg_flr_gen #(
        .NUM_VF   (NUM_VF),
        .VF_IDX_W (VF_IDX_W)
    ) u_flr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flr_req    (wr_devcs_dw && req_wdata[B_FLR]),
        .flr_vf     (req_vf),
        .pf_flr_cap (pf_flr_cap),
        .flr_pulse  (flr_pulse)
    );

    vf_cfg_rd_port #(
        .NUM_VF   (NUM_VF),
        .VF_IDX_W (VF_IDX_W)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_any),
        .rd_vf       (req_vf),
        .rd_dw       (req_dword),
        .st          (vf_st),
        .tx_pending  (tx_pending),
        .pf_link_cap (pf_link_cap),
        .pf_devcap2  (pf_devcap2),
        .pf_deemph   (pf_deemph),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/vf_cfg_regfile_chk.sv
// Module: assertion checker for vf_cfg_regfile, attached by bind.
// Assumes visibility of the top's per-VF state vector vf_st.
module vf_cfg_regfile_chk
    import vf_cfg_pkg::*;
#(
    parameter int NUM_VF   = 4,
    parameter int VF_IDX_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [9:0]             req_dword,
    input logic [31:0]            req_wdata,
    input logic                   pf_perr_en,
    input logic                   pf_serr_en,
    input logic                   pf_flr_cap,
    input logic                   rsp_valid,
    input logic [31:0]            rsp_rdata,
    input logic [NUM_VF-1:0]      flr_pulse,
    input vf_state_t [NUM_VF-1:0] vf_st
);

    assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_ident_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_dword) == DW_IDENT) |-> (rsp_rdata == 32'hFFFF_FFFF));

    assert_flr_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flr_pulse));

    assert_flr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|flr_pulse) |-> $past(req_valid && req_write && req_dword == DW_DEVCS
                               && req_wdata[B_FLR] && pf_flr_cap));

    for (genvar i = 0; i < NUM_VF; i++) begin : g_vf_chk
        assert_perr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(vf_st[i].perr) |-> $past(pf_perr_en));

        assert_sse_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(vf_st[i].sse) |-> $past(pf_serr_en));

        assert_flr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
            flr_pulse[i] |=> (vf_st[i] == '0));
    end

endmodule

bind vf_cfg_regfile vf_cfg_regfile_chk #(
    .NUM_VF   (NUM_VF),
    .VF_IDX_W (VF_IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_dword  (req_dword),
    .req_wdata  (req_wdata),
    .pf_perr_en (pf_perr_en),
    .pf_serr_en (pf_serr_en),
    .pf_flr_cap (pf_flr_cap),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .flr_pulse  (flr_pulse),
    .vf_st      (vf_st)
);

// File: tb/vf_cfg_regfile_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for vf_cfg_regfile. Driver tasks push expected read data;
// a monitor pops and compares at each response.
module vf_cfg_regfile_tb_top;

    localparam int NUM_VF = 4;
    localparam int IW     = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid, req_write;
    logic [IW-1:0]   req_vf;
    logic [9:0]      req_dword;
    logic [31:0]     req_wdata;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic            ev_valid;
    logic [IW-1:0]   ev_vf;
    logic [9:0]      ev_bits;
    logic [NUM_VF-1:0] tx_pending;
    logic            pf_perr_en, pf_serr_en, pf_flr_cap, pf_deemph;
    logic [31:0]     pf_link_cap, pf_devcap2;
    logic [NUM_VF-1:0] flr_pulse;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    vf_cfg_regfile #(.NUM_VF(NUM_VF)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vf(req_vf),
        .req_dword(req_dword), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ev_valid(ev_valid), .ev_vf(ev_vf), .ev_bits(ev_bits),
        .tx_pending(tx_pending),
        .pf_perr_en(pf_perr_en), .pf_serr_en(pf_serr_en), .pf_flr_cap(pf_flr_cap),
        .pf_link_cap(pf_link_cap), .pf_devcap2(pf_devcap2), .pf_deemph(pf_deemph),
        .flr_pulse(flr_pulse)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Monitor: each response is compared with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input int vf, input int ofs, input logic [31:0] exp, input string tag);
        req_valid = 1'b1; req_write = 1'b0;
        req_vf = IW'(vf); req_dword = 10'(ofs >> 2);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input int vf, input int ofs, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1;
        req_vf = IW'(vf); req_dword = 10'(ofs >> 2); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic ev(input int vf, input logic [9:0] b);
        ev_valid = 1'b1; ev_vf = IW'(vf); ev_bits = b;
        @(negedge clk);
        ev_valid = 1'b0; ev_bits = '0;
    endtask

    task automatic wr_ev(input int vf, input int ofs, input logic [31:0] d, input logic [9:0] b);
        ev_valid = 1'b1; ev_vf = IW'(vf); ev_bits = b;
        wr(vf, ofs, d);
        ev_valid = 1'b0; ev_bits = '0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vf = '0;
        req_dword = '0; req_wdata = '0; ev_valid = 1'b0; ev_vf = '0; ev_bits = '0;
        tx_pending = '0; pf_perr_en = 1'b0; pf_serr_en = 1'b0; pf_flr_cap = 1'b0;
        pf_link_cap = 32'h1234_5678; pf_devcap2 = 32'h0ABC_DEF0; pf_deemph = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R11 reset flr_pulse", 32'(flr_pulse), 32'h0);
        rd(0, 'h004, 32'h0010_0000, "R5 reset cmd/status");
        rd(0, 'h048, 32'h0000_0000, "R10 reset dev status");

        // Fixed words
        rd(1, 'h000, 32'hFFFF_FFFF, "R2 identifiers");
        rd(1, 'h00C, 32'h0000_0000, "R2 bist/header");
        rd(1, 'h034, 32'h0000_007C, "R2 cap pointer");
        rd(1, 'h040, 32'h0002_0010, "R2 pcie cap list");

        // Parent mirrors
        rd(2, 'h04C, 32'h1234_5678, "R3 link cap");
        rd(2, 'h054, 32'h0ABC_DEF0, "R3 devcap2");
        rd(2, 'h060, 32'h0001_0000, "R3 deemph 1");
        pf_deemph = 1'b0;
        rd(2, 'h060, 32'h0000_0000, "R3 deemph 0");

        // Zero and ignored locations
        wr(0, 'h050, 32'hFFFF_FFFF);
        wr(0, 'h020, 32'hFFFF_FFFF);
        rd(0, 'h050, 32'h0, "R4 link ctl/sts");
        rd(0, 'h058, 32'h0, "R4 devctl2");
        rd(0, 'h05C, 32'h0, "R4 linkcap2");
        rd(0, 'h020, 32'h0, "R4 unmapped");
        rd(0, 'h004, 32'h0010_0000, "R4 writes ignored");

        // Bus-master enable per VF
        wr(1, 'h004, 32'hFFFF_FFFF);
        rd(1, 'h004, 32'h0010_0004, "R5 bme set vf1");
        rd(0, 'h004, 32'h0010_0000, "R5 vf0 untouched");

        // Parity gate
        ev(2, 10'b00_0000_0001);
        rd(2, 'h004, 32'h0010_0000, "R6 perr gated off");
        pf_perr_en = 1'b1;
        ev(2, 10'b00_0000_0010);
        rd(2, 'h004, 32'h0110_0000, "R6 perr set");

        // Abort bits
        ev(2, 10'b00_0001_1100);
        rd(2, 'h004, 32'h3910_0000, "R7 abort bits");

        // System error gate
        ev(2, 10'b00_0010_0000);
        rd(2, 'h004, 32'h3910_0000, "R8 sse gated off");
        pf_serr_en = 1'b1;
        ev(2, 10'b00_0010_0000);
        rd(2, 'h004, 32'h7910_0000, "R8 sse set");

        // Write-one-to-clear
        wr(2, 'h004, 32'h0800_0000);
        rd(2, 'h004, 32'h7110_0000, "R9 clear bit27");
        wr(2, 'h004, 32'h0000_0000);
        rd(2, 'h004, 32'h7110_0000, "R9 write zero no effect");
        wr(2, 'h004, 32'h7100_0000);
        rd(2, 'h004, 32'h0010_0000, "R9 clear rest");

        // Device status
        ev(3, 10'b11_1100_0000);
        rd(3, 'h048, 32'h000F_0000, "R10 dev status set");
        tx_pending = 4'b1000;
        rd(3, 'h048, 32'h002F_0000, "R10 pending flag");
        tx_pending = '0;
        wr(3, 'h048, 32'h0005_0000);
        rd(3, 'h048, 32'h000A_0000, "R9 dev status clear");

        // Set beats clear on the same edge
        wr_ev(3, 'h048, 32'h000A_0000, 10'b00_1000_0000);
        rd(3, 'h048, 32'h0002_0000, "R13 set wins over clear");

        // FLR
        ev(1, 10'b00_0000_0100);
        wr(2, 'h004, 32'h0000_0004);
        rd(1, 'h004, 32'h0810_0004, "R12 vf1 before flr");
        wr(1, 'h048, 32'h0000_8000);
        check("R11 no pulse without capability", 32'(flr_pulse), 32'h0);
        rd(1, 'h004, 32'h0810_0004, "R11 no reset without capability");
        pf_flr_cap = 1'b1;
        wr(1, 'h048, 32'h0000_8000);
        check("R11 pulse cycle", 32'(flr_pulse), 32'h2);
        @(negedge clk);
        check("R11 pulse one cycle", 32'(flr_pulse), 32'h0);
        rd(1, 'h004, 32'h0010_0000, "R12 vf1 cleared");
        rd(1, 'h048, 32'h0000_0000, "R11 flr bit reads 0");
        rd(2, 'h004, 32'h0010_0004, "R12 vf2 untouched");

        repeat (3) @(negedge clk);
        check("R1 all reads answered", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule